// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank/Power State Tracker

This block watches the command pins of a single-data-rate synchronous DRAM. On every rising clock edge it samples the clock enable, the four active-low strobes (chip select, row strobe, column strobe, write enable), the bank address, address bit 10 and the data mask. It keeps its own copy of the clock-enable level from the previous edge. From these two levels and the strobes it classifies the cycle as exactly one command.

The block keeps an open or closed flag for each bank and a power state: normal, power-down, clock-suspend or self refresh. It checks each command against that state. A command that is not allowed in the current state raises a one-cycle illegal flag and changes no bank. A data-enable output shows whether the data mask lets write data in or read data out in the current cycle.

All outputs are registered. They show the outcome of the command sampled at the previous rising edge. Timing parameters, burst data and mode register contents are not modelled.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: While reset is high and on the first cycle after it, `cmd_code` is all zero, `illegal` and `dq_en` are 0, every `bank_open` bit is 0 and `pwr_state` is 0 (normal).
- R2: `cmd_code` is one-hot and updates one edge after sampling. The bit positions are: 0 deselect, 1 no-op, 2 activate, 3 precharge one bank, 4 precharge all, 5 write, 6 write+auto-precharge, 7 read, 8 read+auto-precharge, 9 mode register set, 10 burst stop, 11 auto refresh, 12 self refresh entry, 13 self refresh exit, 14 power-down/suspend entry, 15 power-down/suspend exit, 16 clock-enable held low, 17 undefined. With clock enable high at both edges, chip select high gives deselect. Otherwise {ras_n,cas_n,we_n} decodes as: 111 no-op, 011 activate, 010 precharge, 100 write, 101 read, 000 mode set, 110 burst stop, 001 auto refresh.
- R3: Activate is legal only when the bank selected by `ba` is closed. A legal activate sets that bank's `bank_open` bit.
- R4: Precharge is always legal. With `a10` low it closes only bank `ba`. With `a10` high it is precharge-all: it closes every bank and `ba` is ignored.
- R5: Read and write, with or without auto-precharge (`a10` high), are legal only when bank `ba` is open. The auto-precharge forms close that bank.
- R6: Mode register set and auto refresh are legal only when every bank is closed.
- R7: Burst stop is legal only when at least one bank is open.
- R8: Clock enable falling with the auto-refresh strobe pattern is self refresh entry. It is legal only with all banks closed and sets `pwr_state` to 3. A later rising clock enable with deselect or no-op is self refresh exit.
- R9: Clock enable falling with deselect or no-op is power entry. `pwr_state` becomes 1 if all banks are closed and 2 if any bank is open. A rising clock enable with deselect or no-op is power exit, which is illegal if `pwr_state` is already 0.
- R10: With clock enable low at both edges, the code is bit 16. `illegal` stays 0 and nothing changes, whatever the strobes show.
- R11: A clock-enable edge with any other strobe pattern decodes as undefined (bit 17) and is illegal. Any rising clock enable returns `pwr_state` to 0.
- R12: An illegal command leaves every `bank_open` bit unchanged.
- R13: `dq_en` is 1 one edge after a sample where clock enable is high, `pwr_state` is 0, at least one bank is open and `dqm` is low. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | All-banks / auto-precharge select |
| dqm | input | 1 | Data mask, high blocks data |
| cmd_code | output | 18 | One-hot decoded command |
| illegal | output | 1 | Command not allowed in the current state |
| bank_open | output | NUM_BANKS | Per-bank open flags |
| pwr_state | output | 2 | 0 normal, 1 power-down, 2 suspend, 3 self refresh |
| dq_en | output | 1 | Data path enabled by the mask |

## Verification
The assertions assume every input is at a defined level at each rising edge. They also assume reset is held for at least one edge before activity, because several properties compare outputs against `$past` values of `ba` and `bank_open`. The bench changes inputs only on falling edges and never leaves a pin undriven. It holds reset for several cycles and, in its random phase, restricts `ba` to the implemented banks. That random phase also biases clock enable toward high, so self refresh and power-down stays end and bank traffic is exercised.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int CMD_N = 18;

    typedef enum logic [4:0] {
        C_DESEL   = 5'd0,
        C_NOP     = 5'd1,
        C_ACT     = 5'd2,
        C_PRE     = 5'd3,
        C_PREA    = 5'd4,
        C_WR      = 5'd5,
        C_WRA     = 5'd6,
        C_RD      = 5'd7,
        C_RDA     = 5'd8,
        C_MRS     = 5'd9,
        C_BST     = 5'd10,
        C_AREF    = 5'd11,
        C_SREF_EN = 5'd12,
        C_SREF_EX = 5'd13,
        C_LP_EN   = 5'd14,
        C_LP_EX   = 5'd15,
        C_HOLD    = 5'd16,
        C_UNDEF   = 5'd17
    } cmd_e;

    typedef enum logic [1:0] {
        PW_NORM  = 2'd0,
        PW_PDOWN = 2'd1,
        PW_SUSP  = 2'd2,
        PW_SELF  = 2'd3
    } pwr_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    // Classification with clock enable high on both edges.
    function automatic cmd_e strobe_cmd(pins_t p, logic a10);
        cmd_e c;
        if (p.cs_n) begin
            c = C_DESEL;
        end else begin
            case ({p.ras_n, p.cas_n, p.we_n})
                3'b111:  c = C_NOP;
                3'b011:  c = C_ACT;
                3'b010:  c = a10 ? C_PREA : C_PRE;
                3'b100:  c = a10 ? C_WRA : C_WR;
                3'b101:  c = a10 ? C_RDA : C_RD;
                3'b000:  c = C_MRS;
                3'b110:  c = C_BST;
                default: c = C_AREF;
            endcase
        end
        return c;
    endfunction

    function automatic logic quiet_pattern(pins_t p);
        return p.cs_n || ({p.ras_n, p.cas_n, p.we_n} == 3'b111);
    endfunction

    function automatic logic refresh_pattern(pins_t p);
        return !p.cs_n && ({p.ras_n, p.cas_n, p.we_n} == 3'b001);
    endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BA_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 cke,
    input  logic                 cke_prev,
    input  pins_t                pins,
    input  logic [BA_W-1:0]      ba,
    input  logic                 a10,
    input  pwr_e                 pwr,
    input  logic [NUM_BANKS-1:0] bank_open,
    output cmd_e                 cmd,
    output logic                 illegal
);
    cmd_e base;
    logic any_open;
    logic sel_open;

    always_comb begin
        base     = strobe_cmd(pins, a10);
        any_open = |bank_open;
        sel_open = bank_open[ba];
        cmd      = base;
        illegal  = 1'b0;
        case ({cke_prev, cke})
            2'b11: begin
                case (base)
                    C_ACT:                    illegal = sel_open;
                    C_WR, C_WRA, C_RD, C_RDA: illegal = !sel_open;
                    C_MRS, C_AREF:            illegal = any_open;
                    C_BST:                    illegal = !any_open;
                    default:                  illegal = 1'b0;
                endcase
            end
            2'b10: begin
                if (refresh_pattern(pins)) begin
                    cmd     = C_SREF_EN;
                    illegal = any_open;
                end else if (quiet_pattern(pins)) begin
                    cmd = C_LP_EN;
                end else begin
                    cmd     = C_UNDEF;
                    illegal = 1'b1;
                end
            end
            2'b01: begin
                if (quiet_pattern(pins)) begin
                    cmd     = (pwr == PW_SELF) ? C_SREF_EX : C_LP_EX;
                    illegal = (pwr == PW_NORM);
                end else begin
                    cmd     = C_UNDEF;
                    illegal = 1'b1;
                end
            end
            default: cmd = C_HOLD;
        endcase
    end
endmodule

// File: rtl/sdcmd_bank_track.sv
module sdcmd_bank_track
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BA_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  cmd_e                 cmd,
    input  logic                 illegal,
    input  logic [BA_W-1:0]      ba,
    output logic [NUM_BANKS-1:0] bank_open
);
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                bank_open[g] <= 1'b0;
            end else if (!illegal) begin
                case (cmd)
                    C_ACT:               if (hit) bank_open[g] <= 1'b1;
                    C_PRE, C_WRA, C_RDA: if (hit) bank_open[g] <= 1'b0;
                    C_PREA:              bank_open[g] <= 1'b0;
                    default:             ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdcmd_power_track.sv
module sdcmd_power_track
    import sdcmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  cmd_e cmd,
    input  logic illegal,
    input  logic any_open,
    output logic cke_prev,
    output pwr_e pwr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cke_prev <= 1'b1;
            pwr      <= PW_NORM;
        end else begin
            cke_prev <= cke;
            if (cke && !cke_prev) begin
                pwr <= PW_NORM;
            end else if (!illegal && cmd == C_SREF_EN) begin
                pwr <= PW_SELF;
            end else if (!illegal && cmd == C_LP_EN) begin
                pwr <= any_open ? PW_SUSP : PW_PDOWN;
            end
        end
    end
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BA_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic                 a10,
    input  logic                 dqm,
    output logic [CMD_N-1:0]     cmd_code,
    output logic                 illegal,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [1:0]           pwr_state,
    output logic                 dq_en
);
    pins_t pins;
    cmd_e  cmd;
    logic  cmd_bad;
    logic  cke_prev;
    pwr_e  pwr;
    logic  any_open;

    assign pins      = '{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n};
    assign any_open  = |bank_open;
    assign pwr_state = pwr;

    sdcmd_decode #(.NUM_BANKS(NUM_BANKS)) decode_i (
        .cke       (cke),
        .cke_prev  (cke_prev),
        .pins      (pins),
        .ba        (ba),
        .a10       (a10),
        .pwr       (pwr),
        .bank_open (bank_open),
        .cmd       (cmd),
        .illegal   (cmd_bad)
    );

    sdcmd_bank_track #(.NUM_BANKS(NUM_BANKS)) banks_i (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .illegal   (cmd_bad),
        .ba        (ba),
        .bank_open (bank_open)
    );

    sdcmd_power_track power_i (
        .clk      (clk),
        .rst      (rst),
        .cke      (cke),
        .cmd      (cmd),
        .illegal  (cmd_bad),
        .any_open (any_open),
        .cke_prev (cke_prev),
        .pwr      (pwr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_code <= '0;
            illegal  <= 1'b0;
            dq_en    <= 1'b0;
        end else begin
            cmd_code <= CMD_N'(1) << cmd;
            illegal  <= cmd_bad;
            dq_en    <= cke && (pwr == PW_NORM) && any_open && !dqm;
        end
    end
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BA_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [BA_W-1:0]      ba,
    input logic [CMD_N-1:0]     cmd_code,
    input logic                 illegal,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [1:0]           pwr_state,
    input logic                 dq_en
);
    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bank_open == '0 && pwr_state == 2'd0 && !illegal)); // R1

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        (cmd_code[C_ACT] && !illegal) |-> bank_open[$past(ba)]); // R3

    AST_PREA_CLOSES: assert property (@(posedge clk) disable iff (rst)
        cmd_code[C_PREA] |-> (bank_open == '0)); // R4

    AST_SELF_ENTER: assert property (@(posedge clk) disable iff (rst)
        (cmd_code[C_SREF_EN] && !illegal) |-> (pwr_state == 2'd3)); // R8

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        cmd_code[C_HOLD] |-> (!illegal && $stable(bank_open))); // R10

    AST_BAD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (bank_open == $past(bank_open))); // R12

    AST_DQ_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
        dq_en |-> $past(|bank_open)); // R13
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ba        (ba),
    .cmd_code  (cmd_code),
    .illegal   (illegal),
    .bank_open (bank_open),
    .pwr_state (pwr_state),
    .dq_en     (dq_en)
);

// File: tb/sdram_cmd_monitor_tb.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_tb_top;
    localparam int NB = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic        a10 = 1'b0;
    logic        dqm = 1'b1;
    logic [17:0] cmd_code;
    logic        illegal;
    logic [NB-1:0] bank_open;
    logic [1:0]  pwr_state;
    logic        dq_en;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // reference model state
    bit [NB-1:0] mb;
    int          mpwr;
    bit          mkp;
    logic [17:0] exp_code;
    bit          exp_ill;
    bit          exp_dq;

    always #2.5 clk = ~clk;

    sdram_cmd_monitor #(.NUM_BANKS(NB)) dut_i (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .dqm(dqm),
        .cmd_code(cmd_code), .illegal(illegal), .bank_open(bank_open),
        .pwr_state(pwr_state), .dq_en(dq_en)
    );

    task automatic compare(string tag);
        checks++;
        if (cmd_code !== exp_code || illegal !== exp_ill || bank_open !== mb ||
            pwr_state !== 2'(mpwr) || dq_en !== exp_dq) begin
            fails++;
            $display("FAIL %s: got code=%h ill=%0b banks=%b pwr=%0d dq=%0b, expected code=%h ill=%0b banks=%b pwr=%0d dq=%0b",
                     tag, cmd_code, illegal, bank_open, pwr_state, dq_en,
                     exp_code, exp_ill, mb, mpwr, exp_dq);
        end
    endtask

    // Behavioural reference: predicts outputs after the next rising edge.
    task automatic model();
        logic [2:0] s;
        bit quiet, refr, sel;
        int opened, c;
        bit il;
        s = {ras_n, cas_n, we_n};
        quiet = cs_n || s == 3'b111;
        refr  = !cs_n && s == 3'b001;
        opened = 0;
        for (int i = 0; i < NB; i++) opened += mb[i];
        sel = mb[ba];
        il = 0;
        c = 16;
        if (mkp && cke) begin
            if (cs_n) c = 0;
            else if (s == 3'b111) c = 1;
            else if (s == 3'b011) begin c = 2; il = sel; end
            else if (s == 3'b010) c = a10 ? 4 : 3;
            else if (s == 3'b100) begin c = a10 ? 6 : 5; il = !sel; end
            else if (s == 3'b101) begin c = a10 ? 8 : 7; il = !sel; end
            else if (s == 3'b000) begin c = 9; il = opened > 0; end
            else if (s == 3'b110) begin c = 10; il = opened == 0; end
            else begin c = 11; il = opened > 0; end
        end else if (mkp && !cke) begin
            if (refr) begin c = 12; il = opened > 0; end
            else if (quiet) c = 14;
            else begin c = 17; il = 1; end
        end else if (!mkp && cke) begin
            if (quiet) begin c = (mpwr == 3) ? 13 : 15; il = (mpwr == 0); end
            else begin c = 17; il = 1; end
        end
        exp_dq   = cke && mpwr == 0 && opened > 0 && !dqm;
        exp_code = 18'(1) << c;
        exp_ill  = il;
        if (!il) begin
            if (c == 2) mb[ba] = 1'b1;
            if (c == 3 || c == 6 || c == 8) mb[ba] = 1'b0;
            if (c == 4) mb = '0;
            if (c == 12) mpwr = 3;
            if (c == 14) mpwr = (opened > 0) ? 2 : 1;
        end
        if (cke && !mkp) mpwr = 0;
        mkp = cke;
    endtask

    // pattern = {ras_n,cas_n,we_n}
    task automatic step(string tag, bit k, bit cs, logic [2:0] pat,
                        int b, bit ap, bit mask);
        cke = k; cs_n = cs; {ras_n, cas_n, we_n} = pat;
        ba = 2'(b); a10 = ap; dqm = mask;
        model();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    localparam logic [2:0] P_NOP = 3'b111, P_ACT = 3'b011, P_PRE = 3'b010,
                           P_WR = 3'b100, P_RD = 3'b101, P_MRS = 3'b000,
                           P_BST = 3'b110, P_REF = 3'b001;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        mb = '0; mpwr = 0; mkp = 1; exp_code = '0; exp_ill = 0; exp_dq = 0;
        compare("R1 reset state");

        step("R2 nop",            1, 0, P_NOP, 0, 0, 1);
        step("R2 deselect",       1, 1, P_ACT, 0, 0, 1);
        step("R3 activate b1",    1, 0, P_ACT, 1, 0, 1);
        step("R3 R12 act open",   1, 0, P_ACT, 1, 0, 1);
        step("R5 read b1",        1, 0, P_RD,  1, 0, 1);
        step("R5 R12 write b2",   1, 0, P_WR,  2, 0, 1);
        step("R13 mask low",      1, 0, P_RD,  1, 0, 0);
        step("R13 mask high",     1, 0, P_NOP, 1, 0, 1);
        step("R7 burst stop",     1, 0, P_BST, 0, 0, 1);
        step("R6 mrs open",       1, 0, P_MRS, 0, 0, 1);
        step("R6 aref open",      1, 0, P_REF, 0, 0, 1);
        step("R3 activate b2",    1, 0, P_ACT, 2, 0, 1);
        step("R4 precharge b2",   1, 0, P_PRE, 2, 0, 1);
        step("R4 precharge all",  1, 0, P_PRE, 0, 1, 1);
        step("R7 bst idle",       1, 0, P_BST, 0, 0, 1);
        step("R6 mrs idle",       1, 0, P_MRS, 0, 0, 1);
        step("R6 aref idle",      1, 0, P_REF, 0, 0, 1);
        step("R3 activate b3",    1, 0, P_ACT, 3, 0, 1);
        step("R5 write ap b3",    1, 0, P_WR,  3, 1, 1);
        step("R3 activate b0",    1, 0, P_ACT, 0, 0, 1);
        step("R5 read ap b0",     1, 0, P_RD,  0, 1, 1);
        step("R9 powerdown in",   0, 0, P_NOP, 0, 0, 1);
        step("R10 hold",          0, 0, P_RD,  0, 0, 0);
        step("R9 powerdown out",  1, 1, P_NOP, 0, 0, 1);
        step("R3 activate b0",    1, 0, P_ACT, 0, 0, 1);
        step("R9 suspend in",     0, 1, P_NOP, 0, 0, 1);
        step("R9 suspend out",    1, 0, P_NOP, 0, 0, 1);
        step("R8 sref open",      0, 0, P_REF, 0, 0, 1);
        step("R9 exit normal",    1, 0, P_NOP, 0, 0, 1);
        step("R4 precharge all",  1, 0, P_PRE, 2, 1, 1);
        step("R8 sref in",        0, 0, P_REF, 0, 0, 1);
        step("R10 hold sref",     0, 0, P_ACT, 1, 0, 1);
        step("R8 sref out",       1, 1, P_NOP, 0, 0, 1);
        step("R11 undef fall",    0, 0, P_ACT, 0, 0, 1);
        step("R9 exit normal",    1, 0, P_NOP, 0, 0, 1);
        step("R9 powerdown in",   0, 0, P_NOP, 0, 0, 1);
        step("R11 undef rise",    1, 0, P_ACT, 2, 0, 1);

        for (int n = 0; n < 600; n++) begin
            bit k;
            k = mkp ? ($urandom_range(0, 9) != 0) : ($urandom_range(0, 2) == 0);
            step("R2 random", k, ($urandom_range(0, 7) == 0),
                 3'($urandom_range(0, 7)), int'($urandom_range(0, NB - 1)),
                 ($urandom_range(0, 3) == 0), $urandom_range(0, 1) == 1);
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule